// File: doc/BRIEF.md
# Low-Delay Data-Only Single-Error-Correcting Decoder

This block guards a 16-bit register word with six check bits and, optionally, one overall parity bit. Its encoder produces the check bits as the word is written. Its decoder takes the stored word, recomputes the check bits and forms a six-bit syndrome. It then corrects a single flipped data bit before the value is used. Check-bit errors are flagged but not repaired. The register is loaded again from its source, never written back from its own read path, so only the data part of the output matters.

Every data column of the parity-check matrix has exactly three ones, and no two columns are equal. A data bit is therefore flipped when the three syndrome bits at its column's ones are all set, whatever the other syndrome bits hold. Each correction signal is a single three-input AND, with no full six-bit compare, and this keeps the decode path short. With `DED_EN` set, the overall parity bit separates odd error counts from even ones. A syndrome that is nonzero while the overall parity is even raises the double-error flag and blocks correction.

The block has no registers. Both the encoder and the decoder settle within the cycle in which their inputs are applied.

Top module: `lowdly_sec_decoder`

## Requirements
- R1: Data column k (k counted from 0) is the k-th six-bit value, in ascending numeric order, that has exactly three ones. Column 0 is 0x07, column 1 is 0x0B, column 15 is 0x2C. Check bit r of `enc_chk_o` is the XOR of the data bits whose column has bit r set.
- R2: `enc_par_o` is the XOR of all 16 data bits and all 6 check bits, so the complete 23-bit codeword has even parity.
- R3: When a valid codeword is presented, `dec_data_o` equals `dec_data_i`, and `dec_err_o` and `dec_dbl_o` are low.
- R4: A single flipped data bit is restored in `dec_data_o`, with `dec_err_o` high and `dec_dbl_o` low.
- R5: A single flipped check bit gives a one-hot syndrome. `dec_err_o` goes high, `dec_data_o` equals the stored data, and `dec_dbl_o` is low.
- R6: A flip of only the parity bit leaves `dec_data_o` equal to the stored data, with both flags low.
- R7: With `DED_EN`=1, any two flipped bits among the 23 raise `dec_dbl_o` and `dec_err_o`, and `dec_data_o` equals the stored data unchanged.
- R8: Data bit k is inverted exactly when every syndrome bit at a one of column k is set. The syndrome bits at its zeros are ignored. With `DED_EN`=0 this rule applies to every input, including double errors.
- R9: With `DED_EN`=0, `dec_dbl_o` is always low and `dec_par_i` has no effect on any output.
- R10: All outputs are combinational functions of the current inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data_i | input | 16 | Data word to encode |
| enc_chk_o | output | 6 | Check bits for enc_data_i |
| enc_par_o | output | 1 | Overall even-parity bit for the encoded word |
| dec_data_i | input | 16 | Stored data bits |
| dec_chk_i | input | 6 | Stored check bits |
| dec_par_i | input | 1 | Stored overall parity bit (used only when DED_EN=1) |
| dec_data_o | output | 16 | Corrected data word |
| dec_err_o | output | 1 | Syndrome nonzero |
| dec_dbl_o | output | 1 | Double error detected (DED_EN=1 only) |

## Verification
There is no register anywhere on the path, so every result is due in the same cycle as its stimulus. The bench drives each vector on the falling clock edge and samples all outputs one nanosecond later, well before the next rising edge. Two instances run side by side, one with the double-error variant and one without. For a set of data words, each instance receives the clean codeword, every one of the 23 single-bit flips and every one of the 253 two-bit flips. The expected outputs come from a column and syndrome model computed in the bench.

// File: rtl/lowdly_ecc_pkg.sv
// Package: column construction shared by the encoder and the decoder.
// Column k is the k-th value, in ascending order, of chk_w bits with
// exactly wt ones. Assumes chk_w <= 16 and a data width <= 64.
package lowdly_ecc_pkg;

    localparam int DATA_W_DEF = 16;
    localparam int CHK_W_DEF  = 6;
    localparam int COL_WT_DEF = 3;

    // Return the idx-th constant-weight column pattern.
    function automatic logic [31:0] col_pattern(input int idx, input int chk_w, input int wt);
        logic [31:0] res;
        int          seen;
        res  = '0;
        seen = 0;
        for (int v = 0; v < (1 << chk_w); v++) begin
            if ($countones(v) == wt) begin
                if (seen == idx) res = v;
                seen++;
            end
        end
        return res;
    endfunction

    // Return the mask of data positions whose column has a one in this row.
    function automatic logic [63:0] row_mask(input int row, input int data_w, input int chk_w, input int wt);
        logic [63:0] m;
        logic [31:0] c;
        m = '0;
        for (int k = 0; k < data_w; k++) begin
            c    = col_pattern(k, chk_w, wt);
            m[k] = c[row];
        end
        return m;
    endfunction

endpackage

// File: rtl/lowdly_chk_gen.sv
// Module: check-bit generator. Each check bit is the XOR of the data bits
// whose column has a one in that row. Purely combinational.
module lowdly_chk_gen #(
    parameter int DATA_W = lowdly_ecc_pkg::DATA_W_DEF,
    parameter int CHK_W  = lowdly_ecc_pkg::CHK_W_DEF,
    parameter int COL_WT = lowdly_ecc_pkg::COL_WT_DEF
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    for (genvar r = 0; r < CHK_W; r++) begin : g_row
        localparam logic [63:0] MASK = lowdly_ecc_pkg::row_mask(r, DATA_W, CHK_W, COL_WT);
        // XOR-reduce the data bits selected by this row.
        always_comb chk_o[r] = ^(data_i & MASK[DATA_W-1:0]);
    end

endmodule

// File: rtl/lowdly_locator.sv
// Module: error locator. Each data bit's flip signal is the AND of the
// syndrome bits at the ones of its column; the zeros are ignored.
// Assumes distinct columns of equal weight COL_WT, so that no column covers another.
module lowdly_locator #(
    parameter int DATA_W = lowdly_ecc_pkg::DATA_W_DEF,
    parameter int CHK_W  = lowdly_ecc_pkg::CHK_W_DEF,
    parameter int COL_WT = lowdly_ecc_pkg::COL_WT_DEF
) (
    input  logic [CHK_W-1:0]  syn_i,
    output logic [DATA_W-1:0] flip_o
);

    for (genvar k = 0; k < DATA_W; k++) begin : g_col
        localparam logic [31:0] COL = lowdly_ecc_pkg::col_pattern(k, CHK_W, COL_WT);
        // AND of the syndrome bits at this column's ones.
        always_comb flip_o[k] = &(syn_i | ~COL[CHK_W-1:0]);
    end

    // Guard the location rule on the syndromes that a single fault can produce.
    always_comb begin
        if ($countones(syn_i) <= COL_WT) begin
            assert_single_flip_R4: assert ($onehot0(flip_o))
                else $error("locator flips more than one bit");
        end
        if ($countones(syn_i) == 1) begin
            assert_chk_err_no_flip_R5: assert (flip_o == '0)
                else $error("check-bit syndrome flips a data bit");
        end
    end

endmodule

// File: rtl/lowdly_sec_decoder.sv
// Module: top level. Holds the encoder, the syndrome and parity logic, the
// locator and the correction XOR. DED_EN selects the double-error variant.
// Assumes a stored word that came from the matching encoder. No registers.
module lowdly_sec_decoder #(
    parameter int DATA_W = lowdly_ecc_pkg::DATA_W_DEF,
    parameter int CHK_W  = lowdly_ecc_pkg::CHK_W_DEF,
    parameter int COL_WT = lowdly_ecc_pkg::COL_WT_DEF,
    parameter bit DED_EN = 1'b1
) (
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CHK_W-1:0]  enc_chk_o,
    output logic              enc_par_o,
    input  logic [DATA_W-1:0] dec_data_i,
    input  logic [CHK_W-1:0]  dec_chk_i,
    input  logic              dec_par_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_err_o,
    output logic              dec_dbl_o
);

    logic [CHK_W-1:0]  recalc_chk;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] flip;
    logic              dbl;

    lowdly_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W), .COL_WT(COL_WT)) u_enc_gen (
        .data_i (enc_data_i),
        .chk_o  (enc_chk_o)
    );

    // Overall parity bit for the write path.
    always_comb enc_par_o = ^{enc_data_i, enc_chk_o};

    lowdly_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W), .COL_WT(COL_WT)) u_dec_gen (
        .data_i (dec_data_i),
        .chk_o  (recalc_chk)
    );

    // Syndrome: stored check bits against recomputed ones.
    always_comb syn = dec_chk_i ^ recalc_chk;

    lowdly_locator #(.DATA_W(DATA_W), .CHK_W(CHK_W), .COL_WT(COL_WT)) u_loc (
        .syn_i  (syn),
        .flip_o (flip)
    );

    if (DED_EN) begin : g_ded
        logic word_odd;
        // Overall parity of the stored word; even plus a nonzero syndrome means two flips.
        always_comb word_odd = ^{dec_data_i, dec_chk_i, dec_par_i};
        always_comb dbl = (|syn) && !word_odd;
    end else begin : g_sec
        logic unused_par;
        // Parity input is not consumed in the plain correcting variant.
        always_comb unused_par = dec_par_i;
        always_comb dbl = 1'b0;
    end

    // Apply the correction unless a double error blocks it.
    always_comb dec_data_o = dec_data_i ^ (flip & {DATA_W{!dbl}});

    // Error flag: any nonzero syndrome.
    always_comb dec_err_o = |syn;

    // Double-error flag.
    always_comb dec_dbl_o = dbl;

    // Output-level checks beside the correction logic.
    always_comb begin
        if (syn == '0) begin
            assert_clean_pass_R3: assert (dec_data_o == dec_data_i && !dec_err_o)
                else $error("clean word altered");
        end
        if (dec_dbl_o) begin
            assert_dbl_no_fix_R7: assert (dec_data_o == dec_data_i && dec_err_o)
                else $error("double error was corrected");
        end
        if (!DED_EN) begin
            assert_sec_no_dbl_R9: assert (!dec_dbl_o)
                else $error("double flag in plain variant");
        end
    end

endmodule

// File: tb/lowdly_sec_decoder_tb.sv
// Bench: encoder sweep plus a decoder sweep over every single and double flip
// of a 23-bit codeword, on one instance with and one without the double-error variant.
module lowdly_sec_decoder_tb;

    localparam int DW = 16;
    localparam int CW = 6;
    localparam int NB = DW + CW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    logic [DW-1:0] enc_d;
    logic [CW-1:0] enc_c_a, enc_c_b;
    logic          enc_p_a, enc_p_b;
    logic [DW-1:0] dd;
    logic [CW-1:0] dc;
    logic          dp;
    logic [DW-1:0] out_a, out_b;
    logic          err_a, err_b, dbl_a, dbl_b;

    lowdly_sec_decoder #(.DED_EN(1'b1)) u_dut (
        .enc_data_i(enc_d), .enc_chk_o(enc_c_a), .enc_par_o(enc_p_a),
        .dec_data_i(dd), .dec_chk_i(dc), .dec_par_i(dp),
        .dec_data_o(out_a), .dec_err_o(err_a), .dec_dbl_o(dbl_a));

    lowdly_sec_decoder #(.DED_EN(1'b0)) u_dut_sec (
        .enc_data_i(enc_d), .enc_chk_o(enc_c_b), .enc_par_o(enc_p_b),
        .dec_data_i(dd), .dec_chk_i(dc), .dec_par_i(dp),
        .dec_data_o(out_b), .dec_err_o(err_b), .dec_dbl_o(dbl_b));

    // Column k: k-th ascending 6-bit value with three ones.
    function automatic logic [CW-1:0] col(input int k);
        int n = 0;
        logic [CW-1:0] r = '0;
        for (int v = 0; v < 64; v++) begin
            if ((v & 1) + ((v >> 1) & 1) + ((v >> 2) & 1) + ((v >> 3) & 1)
                + ((v >> 4) & 1) + ((v >> 5) & 1) == 3) begin
                if (n == k) r = CW'(v);
                n++;
            end
        end
        return r;
    endfunction

    function automatic logic [CW-1:0] model_chk(input logic [DW-1:0] d);
        logic [CW-1:0] c = '0;
        for (int k = 0; k < DW; k++) if (d[k]) c ^= col(k);
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected decoder outputs for one instance.
    task automatic model_dec(input logic [DW-1:0] d, input logic [CW-1:0] c, input logic p, input bit ded,
                             output logic [DW-1:0] o, output logic e, output logic b);
        logic [CW-1:0] s;
        logic odd;
        s = c ^ model_chk(d);
        odd = ^{d, c, p};
        e = (s != '0);
        b = ded && e && !odd;
        o = d;
        if (!b) for (int k = 0; k < DW; k++) if ((s & col(k)) == col(k)) o[k] = ~o[k];
    endtask

    task automatic apply(input logic [NB-1:0] w);
        @(negedge clk);
        dd = w[DW-1:0];
        dc = w[DW+CW-1:DW];
        dp = w[NB-1];
        #1;
    endtask

    // Compare both instances against the model; nflip selects the tag.
    task automatic judge(input logic [NB-1:0] w, input logic [DW-1:0] orig, input int nflip, input int pos);
        logic [DW-1:0] eo_a, eo_b;
        logic ee_a, ee_b, eb_a, eb_b;
        string tg;
        model_dec(w[DW-1:0], w[DW+CW-1:DW], w[NB-1], 1'b1, eo_a, ee_a, eb_a);
        model_dec(w[DW-1:0], w[DW+CW-1:DW], w[NB-1], 1'b0, eo_b, ee_b, eb_b);
        if (nflip == 0) tg = "R3";
        else if (nflip == 2) tg = "R7";
        else if (pos < DW) tg = "R4";
        else if (pos < DW + CW) tg = "R5";
        else tg = "R6";
        check({out_a, err_a, dbl_a} == {eo_a, ee_a, eb_a}, {tg, " ded"}, {out_a, err_a, dbl_a}, {eo_a, ee_a, eb_a});
        check({out_b, err_b, dbl_b} == {eo_b, ee_b, eb_b}, (nflip == 2) ? "R8 sec" : {tg, " sec"},
              {out_b, err_b, dbl_b}, {eo_b, ee_b, eb_b});
        if (nflip == 1 && pos < DW)
            check(out_a == orig && out_b == orig, "R4 restored", out_a, orig);
        if (nflip == 2)
            check(dbl_a && err_a && out_a == w[DW-1:0], "R7 flagged", {dbl_a, err_a}, 2'b11);
        if (nflip == 1 && pos == NB - 1)
            check(out_b == orig && !err_b, "R9 parity ignored", out_b, orig);
        check(!dbl_b, "R9 no dbl", dbl_b, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [NB-1:0] cw;
        enc_d = '0; dd = '0; dc = '0; dp = 1'b0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: zero word is a valid codeword (R3, R10 same-cycle).
        @(negedge clk); #1;
        check(out_a == '0 && !err_a && !dbl_a, "R3 zero word", {out_a, err_a, dbl_a}, 0);
        check(enc_c_a == '0 && !enc_p_a, "R10 encoder zero", enc_c_a, 0);
        // Encoder sweep (R1, R2).
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            enc_d = DW'(i * 40503 + (i >> 3));
            #1;
            check(enc_c_a == model_chk(enc_d) && enc_c_b == enc_c_a, "R1 chk", enc_c_a, model_chk(enc_d));
            check(enc_p_a == ^{enc_d, model_chk(enc_d)}, "R2 par", enc_p_a, ^{enc_d, model_chk(enc_d)});
        end
        check(col(0) == 6'h07 && col(1) == 6'h0B && col(15) == 6'h2C, "R1 columns", col(15), 6'h2C);
        // Decoder sweep: clean, all single flips, all double flips.
        for (int t = 0; t < 8; t++) begin
            d = (t == 0) ? 16'h0000 : (t == 1) ? 16'hFFFF : DW'(t * 24593 ^ 16'hA5C3);
            cw = {^{d, model_chk(d)}, model_chk(d), d};
            apply(cw);
            judge(cw, d, 0, 0);
            for (int a = 0; a < NB; a++) begin
                apply(cw ^ (NB'(1) << a));
                judge(cw ^ (NB'(1) << a), d, 1, a);
            end
            for (int a = 0; a < NB; a++) begin
                for (int b = a + 1; b < NB; b++) begin
                    apply(cw ^ (NB'(1) << a) ^ (NB'(1) << b));
                    judge(cw ^ (NB'(1) << a) ^ (NB'(1) << b), d, 2, a);
                end
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule